// File: doc/BRIEF.md
# Clear-on-read interrupt status unit

This block gathers per-channel alarm events from a round-robin monitoring scan and turns them into a status register and an active-low interrupt line. Events that arrive during a scan pass are held as pending. On the end-of-scan strobe, the unmasked pending events are OR-ed into the status register. Reading the status register returns its value and clears it in the same access.

A configuration register holds a global interrupt enable and an interrupt-clear bit. While the interrupt-clear bit is set, the interrupt line is forced inactive and the scan sequencer is told to stop. The scan resumes when software writes the bit back to 0.

A dedicated over-temperature event does not go into the main status register. It is reported in a separate extended register, which has its own mask bit and is also cleared by a read.

Top module: `irq_status_unit`

## Requirements
- R1: After reset, the status, pending, mask, configuration and extended registers are all 0, `scan_run_o` is 1 and `irq_n_o` is 1.
- R2: A status bit changes from 0 to 1 only on a clock where `scan_end_i` is high and the scan is running. The value OR-ed in is, for each channel, the pending events of the pass plus that cycle's `evt_i` bits, with the pass's pending set emptied at the same time.
- R3: An event on a channel whose bit in the mask register (address 1) is 1 never sets that channel's status bit.
- R4: A read of address 0 returns the status value in `rdata_o` on the next cycle and clears the register. A second read before the next scan end returns 0.
- R5: When a status read and a scan-end update fall in the same cycle, the read returns the old value and the newly latched bits stay set.
- R6: `irq_n_o` is 0 exactly when configuration bit 0 (enable) is 1, configuration bit 3 (interrupt clear) is 0, and the status register or the over-temperature flag holds a bit whose mask is 0.
- R7: While configuration bit 3 is 1, `scan_run_o` is 0, and `scan_end_i` and all event inputs are ignored. When the bit returns to 0, the scan resumes.
- R8: `ot_evt_i` is latched at scan end into bit 0 of the extended register (address 3), unless bit 1 of that register (the over-temperature mask) is 1. A read of address 3 clears bit 0 and leaves bit 1 unchanged.
- R9: The mask register (address 1) and the configuration register (address 2) read back the last written value. A write to address 0 has no effect, and reads of addresses 1 and 2 clear nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NCH | Per-channel alarm event pulses |
| ot_evt_i | input | 1 | Over-temperature event pulse |
| scan_end_i | input | 1 | End-of-scan-pass strobe |
| addr_i | input | AW | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, registered and held until the next read |
| irq_n_o | output | 1 | Active-low interrupt |
| scan_run_o | output | 1 | Scan sequencer run permission |

## Verification
The hardest case to reach is a clearing read that falls in the same cycle as a scan-end update. The read must return the old value while the new bits survive. A second hard case is an event that arrives while the interrupt-clear bit halts the scan. The bench drives both cases with directed sequences. It then runs a long random phase in which reads, strobes, writes and events collide freely, so coincident cycles occur many times. Every cycle is compared against a behavioural model.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int NCH = 8,
  parameter int AW  = 2,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NCH-1:0] evt_i,
  input  logic          ot_evt_i,
  input  logic          scan_end_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_n_o,
  output logic          scan_run_o
);
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_MASK = AW'(1);
  localparam logic [AW-1:0] A_CFG  = AW'(2);
  localparam logic [AW-1:0] A_EXT  = AW'(3);
  localparam int EN_B  = 0;
  localparam int CLR_B = 3;

  logic [NCH-1:0] stat_q, pend_q, mask_q, latch_bits;
  logic [DW-1:0]  cfg_q;
  logic           ot_pend_q, ot_st_q, ot_mask_q;
  logic           run, upd, rd_stat, rd_ext, ot_set;

  assign run        = ~cfg_q[CLR_B];
  assign upd        = scan_end_i & run;
  assign rd_stat    = rd_i & (addr_i == A_STAT);
  assign rd_ext     = rd_i & (addr_i == A_EXT);
  assign latch_bits = upd ? ((pend_q | evt_i) & ~mask_q) : '0;
  assign ot_set     = upd & (ot_pend_q | ot_evt_i) & ~ot_mask_q;
  assign scan_run_o = run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q    <= '0;
      pend_q    <= '0;
      ot_pend_q <= 1'b0;
      ot_st_q   <= 1'b0;
    end else begin
      stat_q  <= (rd_stat ? '0 : stat_q) | latch_bits;
      ot_st_q <= (rd_ext ? 1'b0 : ot_st_q) | ot_set;
      if (upd) begin
        pend_q    <= '0;
        ot_pend_q <= 1'b0;
      end else if (run) begin
        pend_q    <= pend_q | evt_i;
        ot_pend_q <= ot_pend_q | ot_evt_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      cfg_q     <= '0;
      ot_mask_q <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        A_MASK:  mask_q    <= wdata_i[NCH-1:0];
        A_CFG:   cfg_q     <= wdata_i;
        A_EXT:   ot_mask_q <= wdata_i[1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_o <= '0;
    else if (rd_i) begin
      case (addr_i)
        A_STAT:  rdata_o <= DW'(stat_q);
        A_MASK:  rdata_o <= DW'(mask_q);
        A_CFG:   rdata_o <= cfg_q;
        default: rdata_o <= DW'({ot_mask_q, ot_st_q});
      endcase
    end
  end

  assign irq_n_o = ~(cfg_q[EN_B] & ~cfg_q[CLR_B] &
                     ((|(stat_q & ~mask_q)) | (ot_st_q & ~ot_mask_q)));

  // R2
  no_set_without_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ((stat_q & ~$past(stat_q)) == '0));
  // R3
  masked_never_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ~$past(stat_q) & $past(mask_q)) == '0));
  // R4
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !upd) |=> (stat_q == '0));
  // R5
  coincident_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && upd) |=> (stat_q == $past(latch_bits)));
  // R6
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> (cfg_q[EN_B] && !cfg_q[CLR_B]));
  // R7
  halt_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_run_o |=> ($stable(stat_q) || stat_q == '0));
endmodule

// File: tb/test_irq_status_unit.sv
`timescale 1ns/1ps
module test_irq_status_unit;
  localparam int NCH = 8, AW = 2, DW = 8;
  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] evt = '0;
  logic ot_evt = 0, scan_end = 0, wr = 0, rd = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq_n, scan_run;

  irq_status_unit #(.NCH(NCH), .AW(AW), .DW(DW)) i_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .ot_evt_i(ot_evt),
    .scan_end_i(scan_end), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n), .scan_run_o(scan_run));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural model
  int m_stat, m_pend, m_mask, m_cfg, m_ot_pend, m_ot_st, m_ot_mask, m_rdata;

  function automatic bit m_irq_n();
    bit act;
    act = ((m_cfg & 1) != 0) && ((m_cfg & 8) == 0) &&
          (((m_stat & ~m_mask & 255) != 0) || (m_ot_st && !m_ot_mask));
    return !act;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_pend = 0; m_mask = 0; m_cfg = 0;
      m_ot_pend = 0; m_ot_st = 0; m_ot_mask = 0; m_rdata = 0;
    end else begin
      bit running, upd;
      int nstat, not_st;
      running = (m_cfg & 8) == 0;
      upd = scan_end && running;
      nstat = (rd && addr == 0) ? 0 : m_stat;
      not_st = (rd && addr == 3) ? 0 : m_ot_st;
      if (rd) begin
        if (addr == 0) m_rdata = m_stat;
        else if (addr == 1) m_rdata = m_mask;
        else if (addr == 2) m_rdata = m_cfg;
        else m_rdata = m_ot_mask * 2 + m_ot_st;
      end
      if (upd) begin
        nstat = nstat | ((m_pend | int'(evt)) & ~m_mask & 255);
        if ((m_ot_pend || ot_evt) && !m_ot_mask) not_st = 1;
        m_pend = 0; m_ot_pend = 0;
      end else if (running) begin
        m_pend = m_pend | int'(evt);
        m_ot_pend = m_ot_pend | ot_evt;
      end
      m_stat = nstat; m_ot_st = not_st;
      if (wr) begin
        if (addr == 1) m_mask = int'(wdata);
        else if (addr == 2) m_cfg = int'(wdata);
        else if (addr == 3) m_ot_mask = wdata[1];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk(int'(rdata) == m_rdata, "R4 R5 R8 R9 rdata", int'(rdata), m_rdata);
    chk(irq_n == m_irq_n(), "R6 irq_n", int'(irq_n), int'(m_irq_n()));
    chk(scan_run == ((m_cfg & 8) == 0), "R7 scan_run", int'(scan_run), int'((m_cfg & 8) == 0));
  end

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask
  task automatic idle(); rd = 0; wr = 0; scan_end = 0; evt = '0; ot_evt = 0; endtask
  task automatic wreg(input int a, input int d);
    idle(); wr = 1; addr = AW'(a); wdata = DW'(d); cyc(); idle();
  endtask
  task automatic rreg(input int a, output int v);
    idle(); rd = 1; addr = AW'(a); cyc(); v = int'(rdata); idle();
  endtask
  task automatic pass(input int ev);
    idle(); evt = NCH'(ev); cyc(); idle(); scan_end = 1; cyc(); idle();
  endtask

  initial begin
    #150000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    // R1 reset state
    chk(irq_n == 1, "R1 irq_n", int'(irq_n), 1);
    chk(scan_run == 1, "R1 scan_run", int'(scan_run), 1);
    rreg(0, v); chk(v == 0, "R1 status", v, 0);
    rreg(1, v); chk(v == 0, "R1 mask", v, 0);
    wreg(2, 1);
    // R2 nothing before scan end
    idle(); evt = 8'h05; cyc(); idle(); cyc();
    rreg(0, v); chk(v == 0, "R2 no set before end", v, 0);
    scan_end = 1; cyc(); idle();
    chk(irq_n == 0, "R6 asserted", int'(irq_n), 0);
    rreg(0, v); chk(v == 8'h05, "R2 pending latched", v, 8'h05);
    chk(irq_n == 1, "R4 irq drops after read", int'(irq_n), 1);
    rreg(0, v); chk(v == 0, "R4 second read clear", v, 0);
    // R3 masked
    wreg(1, 8'h01); pass(8'h03);
    rreg(0, v); chk(v == 8'h02, "R3 masked bit stays clear", v, 8'h02);
    // R5 coincident read and scan end
    idle(); evt = 8'h10; cyc(); idle();
    rd = 1; addr = 0; scan_end = 1; cyc(); idle();
    chk(int'(rdata) == 0, "R5 old value returned", int'(rdata), 0);
    rreg(0, v); chk(v == 8'h10, "R5 new bit kept", v, 8'h10);
    // R7 halt
    wreg(2, 8'h09);
    chk(scan_run == 0, "R7 halted", int'(scan_run), 0);
    pass(8'h20);
    wreg(2, 8'h01); pass(0);
    rreg(0, v); chk(v == 0, "R7 events ignored while halted", v, 0);
    // R8 over-temperature
    idle(); ot_evt = 1; cyc(); idle(); scan_end = 1; cyc(); idle();
    rreg(0, v); chk(v == 0, "R8 not in main status", v, 0);
    chk(irq_n == 0, "R6 ot irq", int'(irq_n), 0);
    rreg(3, v); chk(v == 1, "R8 ext bit0", v, 1);
    rreg(3, v); chk(v == 0, "R8 ext cleared", v, 0);
    wreg(3, 2); idle(); ot_evt = 1; scan_end = 1; cyc(); idle();
    rreg(3, v); chk(v == 2, "R8 masked ot", v, 2);
    // R9 readback, write to status ignored
    wreg(0, 8'hFF); rreg(0, v); chk(v == 0, "R9 status write ignored", v, 0);
    rreg(2, v); chk(v == 1, "R9 cfg readback", v, 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      evt = NCH'($urandom_range(0, 255) & $urandom_range(0, 255));
      ot_evt = ($urandom_range(0, 9) == 0);
      scan_end = ($urandom_range(0, 7) == 0);
      rd = (r < 30);
      wr = (r >= 90);
      addr = AW'($urandom_range(0, 3));
      wdata = DW'($urandom_range(0, 255));
      if (wr && addr == 2) wdata = DW'((int'(wdata) & 8'hF7) | (($urandom_range(0, 3) == 0) ? 8 : 0));
      cyc();
    end
    idle(); cyc();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule